// File: doc/BRIEF.md
# Processor-Side Bus Handover Arbiter

This block decides when the processor hands its shared external bus to another master. Any number of external masters share one active-low request line, which may be wired-OR. An external master always outranks the processor. The arbiter samples that request through a synchronizer. It then answers on an active-low grant line, but only at a point where the handover cannot cut a processor transfer in half.

The processor's internal bus-cycle sequencer reports its activity to the arbiter:
- a cycle has been decided and is pending;
- a cycle starts this clock, optionally flagged as part of an indivisible read-modify-write sequence;
- a cycle ends;
- the locked sequence ends.

The arbiter returns two controls. A stall stops the sequencer from starting new cycles. A drive enable tells the processor whether to drive its bus outputs. It also shows a locked sequence to the outside world through an active-low lock output.

There is no acknowledge wire. The external master owns the bus for exactly as long as it keeps the request asserted. When the request is negated, the grant is withdrawn. The processor then waits one turnaround clock before it may start a cycle again.

Top module: `xbus_handover`

## Requirements
- R1: During and right after synchronous reset, grant_n_o is 1, drive_en_o is 1, stall_o is 0 and bus_lock_n_o is 1: the processor owns the bus.
- R2: With no cycle running, none pending and no lock, a request sampled low at a rising edge produces grant_n_o = 0 after the third rising edge (two synchronizer stages plus one decision clock).
- R3: If a processor cycle is running when the request is seen, grant_n_o stays 1 until that cycle ends and goes to 0 after the edge that samples cyc_done_i = 1.
- R4: From the start of a cycle flagged with rmw_i = 1 until the edge that samples seq_done_i = 1, bus_lock_n_o is 0 and grant_n_o stays 1, across both the read and the write of the sequence.
- R5: If cyc_pend_i = 1 when the request is seen, grant_n_o stays 1 until that cycle has started (cyc_start_i) and then ended (cyc_done_i); the grant follows the end.
- R6: Whenever grant_n_o = 0, drive_en_o is 0 and stall_o is 1.
- R7: After the request is negated, grant_n_o returns to 1 after the third rising edge. stall_o stays 1 and drive_en_o stays 0 for one more clock, then stall_o is 0 and drive_en_o is 1.
- R8: While waiting for a running unlocked cycle to end, stall_o is 1. While waiting for a pending cycle to start, or between the read and the write of a locked sequence, stall_o is 0.
- R9: A request that is withdrawn before the grant is issued produces no grant. The processor keeps the bus, with stall_o = 0 and drive_en_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n_i | input | 1 | Active-low external bus request, asynchronous, wired-OR |
| cyc_pend_i | input | 1 | Sequencer has decided to run a bus cycle |
| cyc_start_i | input | 1 | A processor bus cycle starts this clock |
| cyc_done_i | input | 1 | The running processor bus cycle ends this clock |
| rmw_i | input | 1 | Qualifies cyc_start_i: the cycle is part of an indivisible sequence |
| seq_done_i | input | 1 | The indivisible sequence ends this clock |
| grant_n_o | output | 1 | Active-low bus grant to the external masters |
| bus_lock_n_o | output | 1 | Active-low indication that the bus is locked |
| stall_o | output | 1 | Forbids the sequencer from starting new cycles |
| drive_en_o | output | 1 | Enables the processor's bus output drivers |

## Verification
The request is raised in five situations, and each one tells a different deferral rule apart:
- **Idle bus.** This pins down the bare synchronizer-plus-decision latency and the release turnaround.
- **Unlocked cycle already running.** This separates "wait for the end" from "grant at once".
- **Locked read-modify-write.** The request is seen during the read. This shows that the grant skips the gap between the read and the write, while the sequencer is still allowed to start the write.
- **Cycle pending but not started.** This shows that the stall is not raised early, which would otherwise deadlock the deferred cycle.
- **Request withdrawn while waiting.** This shows that the arbiter returns to processor ownership without ever pulsing the grant.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

    localparam int unsigned XBH_SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ARB_OWN        = 3'd0,
        ARB_WAIT_START = 3'd1,
        ARB_WAIT_END   = 3'd2,
        ARB_GRANT      = 3'd3,
        ARB_RELEASE    = 3'd4
    } arb_state_e;

    typedef struct packed {
        logic busy;
        logic locked;
    } bus_act_t;

    localparam bus_act_t ACT_IDLE = '{busy: 1'b0, locked: 1'b0};

    function automatic logic act_quiet(input bus_act_t a);
        return !a.busy && !a.locked;
    endfunction

    function automatic logic arb_drives(input arb_state_e s);
        return (s != ARB_GRANT) && (s != ARB_RELEASE);
    endfunction

    function automatic logic arb_stalls(input arb_state_e s, input bus_act_t a);
        logic r;
        case (s)
            ARB_GRANT, ARB_RELEASE: r = 1'b1;
            ARB_WAIT_END:           r = !a.locked;
            default:                r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {N{RESET_VAL}};
        else     chain_q <= {chain_q[N-2:0], d_i};
    end

    assign q_o = chain_q[N-1];
endmodule

// File: rtl/xbh_activity.sv
module xbh_activity
    import xbh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cyc_start_i,
    input  logic     cyc_done_i,
    input  logic     rmw_i,
    input  logic     seq_done_i,
    output bus_act_t act_o,
    output bus_act_t act_nxt_o
);
    bus_act_t act_q;
    bus_act_t act_d;

    always_comb begin
        act_d.busy   = cyc_start_i | (act_q.busy & ~cyc_done_i);
        act_d.locked = (cyc_start_i & rmw_i) | (act_q.locked & ~seq_done_i);
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= ACT_IDLE;
        else     act_q <= act_d;
    end

    assign act_o     = act_q;
    assign act_nxt_o = act_d;
endmodule

// File: rtl/xbh_fsm.sv
module xbh_fsm
    import xbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_seen_i,
    input  logic       cyc_pend_i,
    input  logic       cyc_start_i,
    input  bus_act_t   act_nxt_i,
    output arb_state_e state_o
);
    arb_state_e st_q;
    arb_state_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ARB_OWN: begin
                if (req_seen_i) begin
                    if (!act_quiet(act_nxt_i)) st_d = ARB_WAIT_END;
                    else if (cyc_pend_i)       st_d = ARB_WAIT_START;
                    else                       st_d = ARB_GRANT;
                end
            end
            ARB_WAIT_START: begin
                if (!req_seen_i)              st_d = ARB_OWN;
                else if (cyc_start_i)         st_d = act_quiet(act_nxt_i) ? ARB_GRANT : ARB_WAIT_END;
            end
            ARB_WAIT_END: begin
                if (!req_seen_i)              st_d = ARB_OWN;
                else if (act_quiet(act_nxt_i)) st_d = ARB_GRANT;
            end
            ARB_GRANT: begin
                if (!req_seen_i)              st_d = ARB_RELEASE;
            end
            ARB_RELEASE:                      st_d = ARB_OWN;
            default:                          st_d = ARB_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ARB_OWN;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/xbus_handover.sv
module xbus_handover
    import xbh_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = XBH_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_i,
    input  logic cyc_pend_i,
    input  logic cyc_start_i,
    input  logic cyc_done_i,
    input  logic rmw_i,
    input  logic seq_done_i,
    output logic grant_n_o,
    output logic bus_lock_n_o,
    output logic stall_o,
    output logic drive_en_o
);
    logic       req_n_sync;
    bus_act_t   act_cur;
    bus_act_t   act_nxt;
    arb_state_e state;

    xbh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (req_n_i),
        .q_o (req_n_sync)
    );

    xbh_activity u_act (
        .clk         (clk),
        .rst         (rst),
        .cyc_start_i (cyc_start_i),
        .cyc_done_i  (cyc_done_i),
        .rmw_i       (rmw_i),
        .seq_done_i  (seq_done_i),
        .act_o       (act_cur),
        .act_nxt_o   (act_nxt)
    );

    xbh_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_seen_i  (~req_n_sync),
        .cyc_pend_i  (cyc_pend_i),
        .cyc_start_i (cyc_start_i),
        .act_nxt_i   (act_nxt),
        .state_o     (state)
    );

    assign grant_n_o    = (state != ARB_GRANT);
    assign bus_lock_n_o = ~act_cur.locked;
    assign stall_o      = arb_stalls(state, act_cur);
    assign drive_en_o   = arb_drives(state);
endmodule

// File: rtl/xbh_checker.sv
module xbh_checker (
    input logic clk,
    input logic rst,
    input logic cyc_start_i,
    input logic cyc_done_i,
    input logic grant_n_o,
    input logic bus_lock_n_o,
    input logic stall_o,
    input logic drive_en_o
);
    logic past_rst_q = 1'b0;
    logic chk_busy_q = 1'b0;

    always_ff @(posedge clk) begin
        past_rst_q <= rst;
        if (rst) chk_busy_q <= 1'b0;
        else     chk_busy_q <= cyc_start_i | (chk_busy_q & ~cyc_done_i);
    end

    always_ff @(posedge clk) begin
        if (past_rst_q) begin
            assert_reset_state_R1: assert (grant_n_o && drive_en_o && !stall_o && bus_lock_n_o);
        end
    end

    assert_grant_after_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        !grant_n_o |-> !chk_busy_q);

    assert_lock_blocks_grant_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_lock_n_o |-> grant_n_o);

    assert_granted_offbus_R6: assert property (@(posedge clk) disable iff (rst)
        !grant_n_o |-> (!drive_en_o && stall_o));

    assert_release_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_n_o) |-> (stall_o && !drive_en_o));
endmodule

bind xbus_handover xbh_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cyc_start_i  (cyc_start_i),
    .cyc_done_i   (cyc_done_i),
    .grant_n_o    (grant_n_o),
    .bus_lock_n_o (bus_lock_n_o),
    .stall_o      (stall_o),
    .drive_en_o   (drive_en_o)
);

// File: tb/sim_xbus_handover.sv
module sim_xbus_handover;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_n_i = 1'b1;
    logic cyc_pend_i = 1'b0;
    logic cyc_start_i = 1'b0;
    logic cyc_done_i = 1'b0;
    logic rmw_i = 1'b0;
    logic seq_done_i = 1'b0;
    logic grant_n_o, bus_lock_n_o, stall_o, drive_en_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    xbus_handover u0 (
        .clk(clk), .rst(rst), .req_n_i(req_n_i),
        .cyc_pend_i(cyc_pend_i), .cyc_start_i(cyc_start_i),
        .cyc_done_i(cyc_done_i), .rmw_i(rmw_i), .seq_done_i(seq_done_i),
        .grant_n_o(grant_n_o), .bus_lock_n_o(bus_lock_n_o),
        .stall_o(stall_o), .drive_en_o(drive_en_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_bus(input string req);
        req_n_i = 1'b1;
        nclk(2);
        check(req, "grant held before sync", grant_n_o, 1'b0);
        nclk(1);
        check(req, "grant negated", grant_n_o, 1'b1);
        check(req, "turnaround stall", stall_o, 1'b1);
        check(req, "turnaround drive", drive_en_o, 1'b0);
        nclk(1);
        check(req, "stall dropped", stall_o, 1'b0);
        check(req, "drive restored", drive_en_o, 1'b1);
        nclk(2);
    endtask

    task automatic t_reset;
        nclk(1);
        check("R1", "grant_n", grant_n_o, 1'b1);
        check("R1", "drive_en", drive_en_o, 1'b1);
        check("R1", "stall", stall_o, 1'b0);
        check("R1", "lock_n", bus_lock_n_o, 1'b1);
    endtask

    task automatic t_idle_grant;
        req_n_i = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            nclk(1);
            check("R2", "idle grant latency", grant_n_o, (k < 3) ? 1'b1 : 1'b0);
        end
        check("R6", "drive while granted", drive_en_o, 1'b0);
        check("R6", "stall while granted", stall_o, 1'b1);
        nclk(3);
        check("R6", "grant held with request", grant_n_o, 1'b0);
        release_bus("R7");
    endtask

    task automatic t_busy;
        cyc_start_i = 1'b1;
        nclk(1);
        cyc_start_i = 1'b0;
        req_n_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            nclk(1);
            check("R3", "grant held during cycle", grant_n_o, 1'b1);
        end
        check("R8", "stall waiting for end", stall_o, 1'b1);
        cyc_done_i = 1'b1;
        nclk(1);
        cyc_done_i = 1'b0;
        check("R3", "grant after cycle end", grant_n_o, 1'b0);
        release_bus("R7");
    endtask

    task automatic t_lock;
        cyc_start_i = 1'b1; rmw_i = 1'b1;
        nclk(1);
        cyc_start_i = 1'b0; rmw_i = 1'b0;
        check("R4", "lock shown", bus_lock_n_o, 1'b0);
        req_n_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            nclk(1);
            check("R4", "grant held during read", grant_n_o, 1'b1);
        end
        cyc_done_i = 1'b1;
        nclk(1);
        cyc_done_i = 1'b0;
        check("R4", "grant held between read and write", grant_n_o, 1'b1);
        check("R8", "write may start", stall_o, 1'b0);
        check("R4", "lock still shown", bus_lock_n_o, 1'b0);
        cyc_start_i = 1'b1; rmw_i = 1'b1;
        nclk(1);
        cyc_start_i = 1'b0; rmw_i = 1'b0;
        nclk(2);
        check("R4", "grant held during write", grant_n_o, 1'b1);
        cyc_done_i = 1'b1; seq_done_i = 1'b1;
        nclk(1);
        cyc_done_i = 1'b0; seq_done_i = 1'b0;
        check("R4", "grant after sequence", grant_n_o, 1'b0);
        check("R4", "lock cleared", bus_lock_n_o, 1'b1);
        release_bus("R7");
    endtask

    task automatic t_pend;
        cyc_pend_i = 1'b1;
        req_n_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            nclk(1);
            check("R5", "grant held while pending", grant_n_o, 1'b1);
        end
        check("R8", "no stall before pending start", stall_o, 1'b0);
        cyc_start_i = 1'b1; cyc_pend_i = 1'b0;
        nclk(1);
        cyc_start_i = 1'b0;
        check("R5", "grant held after start", grant_n_o, 1'b1);
        check("R8", "stall after pending start", stall_o, 1'b1);
        nclk(2);
        cyc_done_i = 1'b1;
        nclk(1);
        cyc_done_i = 1'b0;
        check("R5", "grant after pending cycle", grant_n_o, 1'b0);
        release_bus("R7");
    endtask

    task automatic t_withdraw;
        cyc_start_i = 1'b1;
        nclk(1);
        cyc_start_i = 1'b0;
        req_n_i = 1'b0;
        nclk(4);
        check("R9", "no grant yet", grant_n_o, 1'b1);
        req_n_i = 1'b1;
        nclk(3);
        cyc_done_i = 1'b1;
        nclk(1);
        cyc_done_i = 1'b0;
        check("R9", "no grant after withdraw", grant_n_o, 1'b1);
        check("R9", "stall released", stall_o, 1'b0);
        check("R9", "processor drives", drive_en_o, 1'b1);
        for (int k = 0; k < 3; k++) begin
            nclk(1);
            check("R9", "grant stays off", grant_n_o, 1'b1);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        nclk(3);
        rst = 1'b0;
        t_reset();
        nclk(2);
        t_idle_grant();
        t_busy();
        t_lock();
        t_pend();
        t_withdraw();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule